// File: doc/BRIEF.md
# Multiplierless CSD FIR Filter

A direct-form FIR filter whose coefficients are fixed when the design is elaborated. Each coefficient is a vector of signed digits in canonical signed digit form. No tap uses a multiplier. The product for a tap is built by adding or subtracting arithmetically weighted copies of the delayed sample, one term for each nonzero digit. The generate structure leaves out all logic for zero digits.

A new signed sample is accepted on each cycle where `in_valid` is high. The filtered result comes out with `out_valid` a fixed number of edges later. Inside the filter, sums keep full precision. The result is rounded half-up back to the input width and then saturated at the signed limits. The coefficient matrix is a single packed parameter.

Top module: `csd_fir`

## Requirements
- R1: The delay line holds NTAPS samples. On a clock edge where `in_valid` is high it shifts in `in_sample` as the newest sample (tap 0). On any other edge it keeps its contents.
- R2: Each digit is a 2-bit code. 2'b01 means +1, 2'b11 means -1 and 2'b00 means 0. The code 2'b10 is treated as 0. Digit k of tap t sits at bits [2*(t*NDIG+k)+1 : 2*(t*NDIG+k)] of `COEFS`.
- R3: The product for tap t is the sum over k of digit(t,k) * sample(t) * 2^-k. It is kept exactly, with NDIG-1 fractional bits, and formed only by shifts and adds or subtracts.
- R4: The full-precision sum over all taps is rounded half-up to an integer: floor(S + 1/2).
- R5: The rounded value saturates to the range -2^(DW-1) to 2^(DW-1)-1.
- R6: `out_valid` is high in the cycle that follows the second clock edge after the edge that accepted a sample, and low otherwise. `out_sample` then holds the result for the delay-line state that the accepting edge produced.
- R7: `out_sample` keeps its last value while `out_valid` is low.
- R8: `rst_n` is active-low and asynchronous. It clears the delay line, the pipeline and `out_valid` at once. Its release passes through two synchronizing flops before samples are accepted again.
- R9: By default the filter has 50 taps of 11 digits each and 24-bit samples. A sample reaches no output more than 50 accepted samples after it entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_sample` |
| in_sample | input | DW | Signed input sample |
| out_valid | output | 1 | Qualifies `out_sample` |
| out_sample | output | DW | Signed filtered, rounded, saturated result |

## Verification
The bench keeps the default sizes: 50 taps, 11 digits and 24-bit samples. It overrides `COEFS` with its own canonical pattern, which has both signs in every tap and the illegal code 2'b10 at digit 2 of several taps, so an impulse exposes any wrong decode of that code. With 50 taps of large total gain, full-scale inputs whose signs follow the coefficient signs push the result past both signed limits, which brings saturation in both directions within reach.

// File: rtl/csd_fir_pkg.sv
`timescale 1ns/1ps
package csd_fir_pkg;

  localparam logic [1:0] DIG_ZERO = 2'b00;
  localparam logic [1:0] DIG_POS  = 2'b01;
  localparam logic [1:0] DIG_NEG  = 2'b11;

  localparam int COEF_MAX_BITS = 4096;

  // Default canonical coefficient pattern: no two adjacent nonzero digits.
  function automatic logic [COEF_MAX_BITS-1:0] default_coefs(int ntaps, int ndig);
    logic [COEF_MAX_BITS-1:0] v;
    v = '0;
    for (int t = 0; t < ntaps; t++) begin
      for (int k = 0; k < ndig; k++) begin
        if ((2*(t*ndig+k)+1 < COEF_MAX_BITS) && ((t + 2*k) % 5 == 0))
          v[2*(t*ndig+k) +: 2] = (k % 2 == 1) ? DIG_NEG : DIG_POS;
      end
    end
    return v;
  endfunction

endpackage

// File: rtl/csd_rst_sync.sv
`timescale 1ns/1ps
module csd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/csd_delay_line.sv
`timescale 1ns/1ps
module csd_delay_line #(
  parameter int NTAPS = 50,
  parameter int DW    = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [DW-1:0]               din,
  output logic [NTAPS-1:0][DW-1:0]    taps
);
  logic [NTAPS-1:0][DW-1:0] taps_d, taps_q;

  always_comb begin
    taps_d = taps_q;
    if (en) begin
      taps_d[0] = din;
      for (int i = 1; i < NTAPS; i++) taps_d[i] = taps_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps_q <= '0;
    else        taps_q <= taps_d;
  end

  assign taps = taps_q;

  // R1: with no accepted sample the oldest tap keeps its value
  p_hold_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(taps_q[NTAPS-1]));
endmodule

// File: rtl/csd_tap.sv
`timescale 1ns/1ps
module csd_tap #(
  parameter int              DW     = 24,
  parameter int              NDIG   = 11,
  parameter logic [2*NDIG-1:0] DIGITS = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic signed [DW-1:0]  x,
  output logic [DW+NDIG-1:0]    prod
);
  import csd_fir_pkg::*;
  localparam int PW = DW + NDIG;

  logic signed [PW-1:0] xe;
  logic signed [PW-1:0] terms [NDIG];
  logic signed [PW-1:0] prod_d, prod_q;

  assign xe = PW'(x);

  // One shifted term per digit; the digit code picks the variant.
  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    localparam logic [1:0] CODE = DIGITS[2*k +: 2];
    localparam int SH = NDIG - 1 - k;
    if (CODE == DIG_POS) begin : g_pos
      assign terms[k] = xe <<< SH;
    end else if (CODE == DIG_NEG) begin : g_neg
      assign terms[k] = -(xe <<< SH);
    end else begin : g_zero
      assign terms[k] = '0;
    end
  end

  always_comb begin
    prod_d = '0;
    for (int k = 0; k < NDIG; k++) prod_d = prod_d + terms[k];
    if (!en) prod_d = prod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= prod_d;
  end

  assign prod = prod_q;
endmodule

// File: rtl/csd_acc_round.sv
`timescale 1ns/1ps
module csd_acc_round #(
  parameter int NTAPS = 50,
  parameter int DW    = 24,
  parameter int PW    = 35,
  parameter int FRAC  = 10,
  parameter int SW    = 41
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [NTAPS-1:0][PW-1:0]   prods,
  output logic                       out_valid,
  output logic signed [DW-1:0]       out_sample
);
  localparam logic signed [SW-1:0] HALF   = SW'(64'd1 << (FRAC-1));
  localparam logic signed [SW-1:0] SAT_HI = SW'((64'sd1 <<< (DW-1)) - 64'sd1);
  localparam logic signed [SW-1:0] SAT_LO = ~SAT_HI;

  logic signed [SW-1:0] acc, rounded, clipped;
  logic signed [DW-1:0] out_d, out_q;
  logic                 vld_d, vld_q;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NTAPS; i++) acc = acc + SW'($signed(prods[i]));
    rounded = (acc + HALF) >>> FRAC;
    if (rounded > SAT_HI)      clipped = SAT_HI;
    else if (rounded < SAT_LO) clipped = SAT_LO;
    else                       clipped = rounded;
    out_d = en ? clipped[DW-1:0] : out_q;
    vld_d = en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      out_q <= out_d;
      vld_q <= vld_d;
    end
  end

  assign out_sample = out_q;
  assign out_valid  = vld_q;

  // R7: result held between valid outputs
  p_hold_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(out_q));
endmodule

// File: rtl/csd_fir.sv
`timescale 1ns/1ps
module csd_fir
  import csd_fir_pkg::*;
#(
  parameter int NTAPS = 50,
  parameter int NDIG  = 11,
  parameter int DW    = 24,
  parameter logic [2*NTAPS*NDIG-1:0] COEFS =
    (2*NTAPS*NDIG)'(csd_fir_pkg::default_coefs(NTAPS, NDIG))
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample
);
  localparam int PW   = DW + NDIG;
  localparam int FRAC = NDIG - 1;
  localparam int SW   = PW + $clog2(NTAPS);

  logic rst_sync_n;
  logic [NTAPS-1:0][DW-1:0] taps;
  logic [NTAPS-1:0][PW-1:0] prods;
  logic dl_valid_d, dl_valid_q, prod_valid_d, prod_valid_q;

  csd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  csd_delay_line #(.NTAPS(NTAPS), .DW(DW)) u_dl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (in_valid),
    .din   (in_sample),
    .taps  (taps)
  );

  always_comb begin
    dl_valid_d   = in_valid;
    prod_valid_d = dl_valid_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dl_valid_q   <= 1'b0;
      prod_valid_q <= 1'b0;
    end else begin
      dl_valid_q   <= dl_valid_d;
      prod_valid_q <= prod_valid_d;
    end
  end

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    csd_tap #(
      .DW     (DW),
      .NDIG   (NDIG),
      .DIGITS (COEFS[2*NDIG*t +: 2*NDIG])
    ) u_tap (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (dl_valid_q),
      .x     (taps[t]),
      .prod  (prods[t])
    );
  end

  csd_acc_round #(
    .NTAPS (NTAPS), .DW (DW), .PW (PW), .FRAC (FRAC), .SW (SW)
  ) u_acc (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en         (prod_valid_q),
    .prods      (prods),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  // R1: accepted sample becomes the newest tap
  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> (taps[0] == $past(in_sample)));

  // R6: accepted sample yields a valid result after two more edges
  p_valid_latency_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |-> ##3 out_valid);

  // R6: no accepted sample, no valid result
  p_idle_no_valid_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |-> ##3 !out_valid);

  // R8: reset keeps the output qualifier low
  p_reset_clear_r8: assert property (@(posedge clk)
    !rst_sync_n |-> !out_valid);
endmodule

// File: tb/test_csd_fir.sv
`timescale 1ns/1ps
module test_csd_fir;
  localparam int NT = 50;
  localparam int ND = 11;
  localparam int W  = 24;
  localparam longint MAXV = 8388607;
  localparam longint MINV = -8388608;

  function automatic logic [2*NT*ND-1:0] tb_coefs();
    logic [2*NT*ND-1:0] v;
    v = '0;
    for (int t = 0; t < NT; t++)
      for (int k = 0; k < ND; k++) begin
        if ((t + k) % 3 == 0)
          v[2*(t*ND+k) +: 2] = ((t*5 + k) % 4 < 2) ? 2'b01 : 2'b11;
        else if (k == 2 && t % 7 == 5)
          v[2*(t*ND+k) +: 2] = 2'b10;
      end
    return v;
  endfunction

  localparam logic [2*NT*ND-1:0] TB_COEFS = tb_coefs();

  // stimulus table: {in_valid, sample}; gaps exercise R1
  localparam logic [24:0] STIM [16] = '{
    25'h1000400, 25'h1FFFC00, 25'h0123456, 25'h1001234,
    25'h0ABCDEF, 25'h0000000, 25'h17FFFFF, 25'h1800000,
    25'h1000001, 25'h0555555, 25'h1FFFFFF, 25'h1400000,
    25'h0000000, 25'h1020304, 25'h13FFFFF, 25'h1C00000
  };

  logic clk, rst_n, in_valid;
  logic signed [W-1:0] in_sample;
  logic out_valid;
  logic signed [W-1:0] out_sample;

  csd_fir #(.NTAPS(NT), .NDIG(ND), .DW(W), .COEFS(TB_COEFS)) i_csd_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string cur_tag = "R3";
  longint mdl [NT];
  bit     hv [3];
  longint hx [3];
  longint last_out;

  function automatic longint dig(int t, int k);
    logic [1:0] c;
    c = TB_COEFS[2*(t*ND+k) +: 2];
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  function automatic longint ctap(int t);
    longint s = 0;
    for (int k = 0; k < ND; k++) s += dig(t, k) * (longint'(1) << (ND-1-k));
    return s;
  endfunction

  function automatic longint ref_now();
    longint acc = 0, r;
    for (int t = 0; t < NT; t++) acc += ctap(t) * mdl[t];
    r = (acc + 512) >>> 10;
    if (r > MAXV) r = MAXV;
    if (r < MINV) r = MINV;
    return r;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < NT; i++) mdl[i] = 0;
    for (int i = 0; i < 3; i++) begin hv[i] = 0; hx[i] = 0; end
    last_out = 0;
  endtask

  // drive one cycle, update model, check outputs away from the edge
  task automatic step(bit v, longint x);
    in_valid  = v;
    in_sample = W'(x);
    @(posedge clk);
    #1;
    if (v) begin
      for (int i = NT-1; i > 0; i--) mdl[i] = mdl[i-1];
      mdl[0] = x;
    end
    for (int i = 2; i > 0; i--) begin hv[i] = hv[i-1]; hx[i] = hx[i-1]; end
    hv[0] = v;
    hx[0] = v ? ref_now() : 0;
    @(negedge clk);
    chk(out_valid == hv[2], "R6", longint'(out_valid), longint'(hv[2]));
    if (hv[2]) begin
      chk(longint'(out_sample) == hx[2], cur_tag, longint'(out_sample), hx[2]);
      last_out = hx[2];
    end else begin
      chk(longint'(out_sample) == last_out, "R7", longint'(out_sample), last_out);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R8", longint'(out_valid), 0);
    chk(out_sample == '0, "R8", longint'(out_sample), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    repeat (3) step(0, 0);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    in_valid = 0; in_sample = '0; rst_n = 1'b0;
    clear_model();
    @(negedge clk);
    do_reset();

    // R1: table walk with gaps
    cur_tag = "R1";
    foreach (STIM[i]) step(STIM[i][24], longint'($signed(STIM[i][23:0])));
    repeat (3) step(0, 0);

    // R2 R3 R9: impulse reads back each tap, then leaves after NT samples
    cur_tag = "R2 R3 R9";
    clear_model();
    do_reset();
    step(1, 1024);
    for (int i = 0; i < NT + 2; i++) step(1, 0);
    chk(longint'(out_sample) == 0, "R9", longint'(out_sample), 0);

    // R4: step input
    cur_tag = "R4";
    for (int i = 0; i < 60; i++) step(1, 300001);

    // R5: full-scale alternating signs
    cur_tag = "R5";
    for (int i = 0; i < 60; i++) step(1, (i % 2) ? MINV : MAXV);

    // R4: random samples with idle gaps
    cur_tag = "R4";
    for (int i = 0; i < 200; i++) begin
      logic signed [W-1:0] r;
      r = W'($urandom);
      step((i % 9) != 4, longint'(r));
    end

    // R5: signs matched to coefficients -> positive clip
    cur_tag = "R5";
    for (int i = 0; i < NT; i++) step(1, (ctap(NT-1-i) >= 0) ? MAXV : MINV);
    step(0, 0); step(0, 0);
    chk(longint'(out_sample) == MAXV, "R5", longint'(out_sample), MAXV);

    // R5: opposite signs -> negative clip
    for (int i = 0; i < NT; i++) step(1, (ctap(NT-1-i) >= 0) ? MINV : MAXV);
    step(0, 0); step(0, 0);
    chk(longint'(out_sample) == MINV, "R5", longint'(out_sample), MINV);

    // R8: reset mid-stream, then impulse must show no residue
    cur_tag = "R8";
    for (int i = 0; i < 5; i++) step(1, 777777);
    do_reset();
    step(1, 2048);
    for (int i = 0; i < 6; i++) step(1, 0);
    repeat (3) step(0, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule